// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Contention Arbitration

A synchronous true dual-port memory with two identical ports, left and right. Each port has its own enable, write strobe, address, write data and read data. When both ports are enabled at the same address in the same cycle, the block decides which port may proceed. It raises an active-low busy flag to the other port and suppresses that port's write. A write that is held stays pending for as long as its strobe stays asserted, and it lands in the first cycle its busy flag is clear.

Arrival order is judged per clock. A port that already presented the contested address with its enable set in the previous cycle counts as earlier than a port that arrives in the current cycle. If both arrive together, the left port wins. The winner is remembered for as long as the match lasts.

A mode input selects master or slave behaviour. In slave mode the internal arbitration is bypassed: both busy outputs stay inactive, and per-port busy inputs from an external master gate the writes. This lets several memories be cascaded for wider words. The depth is 2**ADDR_W words of DATA_W bits. Setting ADDR_W to 13 gives an 8K-word array.

Top module: `dpram_contend`

## Requirements
- R1: During and right after reset, both busy outputs are high (inactive) and both read data outputs are zero.
- R2: At a clock edge where a port has enable=1, write strobe=1 and no busy applied to it, that port's write data is stored at its address.
- R3: At every edge where a port's enable is 1, its read data output loads the word that was stored at its address before that edge's writes. With enable=0 the read data output holds its value.
- R4: In master mode, a port's busy output is low only while both enables are 1 and the two addresses are equal. At most one busy output is low at a time.
- R5: In master mode, a port that had enable=1 at the same address in the previous cycle wins against a port that just arrived. The newcomer gets busy.
- R6: In master mode, when both ports start matching in the same cycle with neither earlier, the left port wins and the right port gets busy.
- R7: Once a winner is chosen it is kept until the match ends, even if the arrival rule would choose differently later.
- R8: A write from a port whose busy is in force does not change the memory.
- R9: A write held by busy completes at the first edge where busy is no longer applied, provided enable and the write strobe are still 1.
- R10: In slave mode both busy outputs stay high. Each port's write is gated by its busy input (low = blocked), and no internal arbitration takes place.
- R11: A word written on one port is returned to the other port by a read at the next edge or later. If both ports write the same address at the same edge unblocked (only possible in slave mode), the left port's data is stored.
- R12: Two simultaneous reads of one address are arbitrated and flagged like any other match, yet both ports return the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = internal arbitration, 0 = slave (busy taken from inputs) |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_busy_in_n | input | 1 | Left busy from external master, slave mode only, active low |
| l_rdata | output | DATA_W | Left port read data |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_busy_in_n | input | 1 | Right busy from external master, slave mode only, active low |
| r_rdata | output | DATA_W | Right port read data |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
Arbitration and storage collide in the same cycle whenever both ports write one address at once. The bench drives such a pair in several forms: a tied arrival, a late arrival against a standing reader, and a moved address against a standing writer. A cycle-level behavioural model in the bench predicts which busy flag falls and which data the array keeps. Both ports then read the address back on the following cycles, so a write that should have been blocked, or a held write that failed to complete, shows up as wrong read data.

// File: rtl/dpram_contend.sv
module dpram_contend #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_in_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_in_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] OWN_NONE = 2'd0, OWN_L = 2'd1, OWN_R = 2'd2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic [1:0]        owner_q, winner;

  wire match = l_en && r_en && (l_addr == r_addr);
  wire l_old = l_en_q && (l_addr_q == l_addr);
  wire r_old = r_en_q && (r_addr_q == r_addr);

  always_comb begin
    if (owner_q != OWN_NONE)  winner = owner_q;
    else if (r_old && !l_old) winner = OWN_R;
    else                      winner = OWN_L;
  end

  wire l_lose  = master && match && (winner == OWN_R);
  wire r_lose  = master && match && (winner == OWN_L);
  wire l_block = master ? l_lose : !l_busy_in_n;
  wire r_block = master ? r_lose : !r_busy_in_n;

  assign l_busy_n = !l_lose;
  assign r_busy_n = !r_lose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      owner_q  <= OWN_NONE;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      owner_q  <= (master && match) ? winner : OWN_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (r_en && r_we && !r_block) mem[r_addr] <= r_wdata;
    if (l_en && l_we && !l_block) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en) l_rdata <= mem[l_addr];
      if (r_en) r_rdata <= mem[r_addr];
    end
  end
endmodule

// File: rtl/dpram_contend_chk.sv
module dpram_contend_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_n,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  wire same = l_en && r_en && (l_addr == r_addr);

  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (l_busy_n && r_busy_n));

  p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  p_busy_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> same);

  p_tie_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && master && same && !$past(l_en) && !$past(r_en)) |-> (l_busy_n && !r_busy_n));

  p_winner_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && master && same && $past(master) && $past(same) && !$past(l_busy_n)) |-> !l_busy_n);

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(l_en)) |-> $stable(l_rdata));
endmodule

bind dpram_contend dpram_contend_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .master(master),
  .l_en(l_en), .l_addr(l_addr), .l_rdata(l_rdata), .l_busy_n(l_busy_n),
  .r_en(r_en), .r_addr(r_addr), .r_busy_n(r_busy_n)
);

// File: tb/dpram_contend_tb_top.sv
module dpram_contend_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic l_en = 0, l_we = 0, l_bin = 1, r_en = 0, r_we = 0, r_bin = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n, r_busy_n;

  always #4 clk = ~clk;

  dpram_contend #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_busy_in_n(l_bin), .l_rdata(l_rdata), .l_busy_n(l_busy_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_busy_in_n(r_bin), .r_rdata(r_rdata), .r_busy_n(r_busy_n)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  int m_mem [NW];
  int m_lr = 0, m_rr = 0, m_own = 0, m_la = 0, m_ra = 0;
  bit m_le = 0, m_re = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit m,
                      bit le, bit lw, int la, int lwd, bit lbi,
                      bit re, bit rw, int ra, int rwd, bit rbi);
    bit mt, lold, rold, bl, br, lblk, rblk;
    int win, ol, orr;
    @(negedge clk);
    chk(tag, "l_rdata", int'(l_rdata), m_lr);
    chk(tag, "r_rdata", int'(r_rdata), m_rr);
    master = m; l_en = le; l_we = lw; l_addr = AW'(la); l_wdata = DW'(lwd); l_bin = lbi;
    r_en = re; r_we = rw; r_addr = AW'(ra); r_wdata = DW'(rwd); r_bin = rbi;
    #1;
    mt = le && re && (la == ra);
    lold = m_le && (m_la == la);
    rold = m_re && (m_ra == ra);
    win = 0; bl = 0; br = 0;
    if (m && mt) begin
      if (m_own != 0) win = m_own;
      else if (rold && !lold) win = 2;
      else win = 1;
      bl = (win == 2);
      br = (win == 1);
    end
    chk(tag, "l_busy_n", int'(l_busy_n), int'(!bl));
    chk(tag, "r_busy_n", int'(r_busy_n), int'(!br));
    lblk = m ? bl : !lbi;
    rblk = m ? br : !rbi;
    ol = m_mem[la]; orr = m_mem[ra];
    if (le) m_lr = ol;
    if (re) m_rr = orr;
    if (re && rw && !rblk) m_mem[ra] = rwd;
    if (le && lw && !lblk) m_mem[la] = lwd;
    m_own = (m && mt) ? win : 0;
    m_le = le; m_re = re; m_la = la; m_ra = ra;
  endtask

  task automatic idle(string tag, bit m);
    step(tag, m, 0,0,0,0,1, 0,0,0,0,1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "l_busy_n", int'(l_busy_n), 1);
    chk("R1", "r_busy_n", int'(r_busy_n), 1);
    chk("R1", "l_rdata", int'(l_rdata), 0);
    chk("R1", "r_rdata", int'(r_rdata), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: fill from left, then from right
    for (int i = 0; i < NW; i++) step("R2", 1, 1,1,i,16'h1000+i,1, 0,0,0,0,1);
    for (int i = 0; i < NW/2; i++) step("R2", 1, 0,0,0,0,1, 1,1,i,16'h2000+i,1);
    // R3 / R11: cross-port readback
    for (int i = 0; i < NW; i++) step("R11", 1, 1,0,NW-1-i,0,1, 1,0,i,0,1);
    idle("R3", 1);
    idle("R3", 1);

    // R5 / R8 / R9: left standing reader at 3, right arrives writing
    step("R5", 1, 1,0,3,0,1, 0,0,0,0,1);
    step("R5", 1, 1,0,3,0,1, 1,1,3,16'hBEEF,1);
    step("R8", 1, 1,0,3,0,1, 1,1,3,16'hBEEF,1);
    step("R8", 1, 1,0,3,0,1, 1,1,3,16'hBEEF,1);
    step("R9", 1, 0,0,0,0,1, 1,1,3,16'hBEEF,1);
    step("R9", 1, 1,0,3,0,1, 0,0,0,0,1);
    step("R9", 1, 0,0,0,0,1, 0,0,0,0,1);

    // R5: right first, left arrives writing
    step("R5", 1, 0,0,0,0,1, 1,0,6,0,1);
    step("R5", 1, 1,1,6,16'h0BAD,1, 1,0,6,0,1);
    step("R8", 1, 1,1,6,16'h0BAD,1, 1,0,6,0,1);
    step("R8", 1, 0,0,0,0,1, 1,0,6,0,1);
    idle("R8", 1);

    // R6: tie, both write same address
    step("R6", 1, 1,1,9,16'hAAAA,1, 1,1,9,16'h5555,1);
    step("R6", 1, 1,1,9,16'hAAAA,1, 1,1,9,16'h5555,1);
    step("R9", 1, 0,0,0,0,1, 1,1,9,16'h5555,1);
    step("R11", 1, 1,0,9,0,1, 0,0,0,0,1);
    idle("R11", 1);

    // R7: right standing at 5, left moves onto 5
    step("R7", 1, 1,0,4,0,1, 1,1,5,16'h7777,1);
    step("R7", 1, 1,1,5,16'h1111,1, 1,1,5,16'h7777,1);
    step("R7", 1, 1,1,5,16'h1111,1, 1,1,5,16'h7777,1);
    step("R7", 1, 1,1,5,16'h1111,1, 1,1,5,16'h7777,1);
    step("R9", 1, 1,0,5,0,1, 0,0,0,0,1);
    idle("R9", 1);

    // R12: simultaneous reads
    step("R12", 1, 1,0,10,0,1, 1,0,10,0,1);
    step("R12", 1, 1,0,10,0,1, 1,0,10,0,1);
    idle("R12", 1);

    // R11: write on left, read same address on right in the same and next cycle
    step("R11", 1, 1,1,12,16'hC0DE,1, 1,0,13,0,1);
    step("R11", 1, 1,1,14,16'hFACE,1, 1,0,14,0,1);
    step("R11", 1, 0,0,0,0,1, 1,0,14,0,1);
    idle("R11", 1);

    // R10: slave mode
    step("R10", 0, 1,1,2,16'h2222,1, 1,1,2,16'h3333,1);
    step("R10", 0, 1,0,2,0,1, 1,0,2,0,1);
    step("R10", 0, 1,1,8,16'h8888,1, 1,1,11,16'h9999,0);
    step("R10", 0, 1,1,7,16'h4444,0, 1,1,7,16'h6666,1);
    step("R10", 0, 1,0,11,0,1, 1,0,7,0,1);
    step("R10", 0, 1,0,8,0,1, 0,0,0,0,1);
    idle("R10", 0);
    idle("R10", 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule